// File: doc/BRIEF.md
# Interrupt Pending and Request Unit

This block holds the pending-interrupt state of a processor's system-control unit and decides whether the pipeline must take an interrupt. It keeps eight pending bits. Software and hardware sources set or clear single bits by level number, or wipe the whole field at once. A free-running 32-bit counter is compared against a programmable match value. When they meet, the pending bit chosen by a 3-bit timer-index input is raised. Rewriting the match value acknowledges that timer bit.

The pending bits are ANDed bit for bit with an 8-bit enable mask. The result is then qualified by three status inputs: a global enable, an exception-level flag and an error-level flag. The outcome drives one registered request line into the pipeline. A second, ungated output reports whether any bit is pending at all. A level number outside the legal range is refused and flagged.

Top module: `irq_pending_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has all pending bits at 0, the counter at 0, the match value at 0, and `irq_req` and `lvl_err` at 0.
- R2: A post with a legal level n (0 to 7 on the 4-bit `post_lvl`) sets `pend[n]` at the next edge. Every other bit keeps its value.
- R3: A clear with a legal level n clears `pend[n]` and leaves the others alone. `clr_all` drives all eight bits to 0.
- R4: A post or clear whose level is 8 to 15 leaves `pend` unchanged and raises `lvl_err` for exactly the following cycle.
- R5: Any set beats any clear on the same bit in the same cycle. This holds for a post against a clear, a post against `clr_all`, and a timer match against a match-value write.
- R6: `irq_req` is registered. It is high in the cycle after an edge at which `ie`=1, `exl`=0, `erl`=0 and `(im & pend)` is nonzero. Otherwise it is low.
- R7: If `ie` is 0, or `exl` is 1, or `erl` is 1 at an edge, `irq_req` is low after that edge, whatever the mask and pending bits are.
- R8: The counter adds one at each edge where `cnt_en` is high. It wraps from 0xFFFFFFFF to 0. A `cnt_wr` loads `cnt_wdata` instead and takes priority over the increment.
- R9: When the counter equals the match value and the counter is nonzero, `pend[timer_idx]` is set at the next edge. Other bits are not touched.
- R10: Counter and match value both equal to 0 is not a match and sets nothing.
- R11: A `cmp_wr` loads `cmp_wdata` as the match value and clears `pend[timer_idx]`, unless that bit is being set in the same cycle.
- R12: `any_pend` is high exactly when `pend` is nonzero, independent of `im`, `ie`, `exl` and `erl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_lvl | input | 4 | Level to set; 8 to 15 illegal |
| clr_vld | input | 1 | Clear request strobe |
| clr_lvl | input | 4 | Level to clear; 8 to 15 illegal |
| clr_all | input | 1 | Clear every pending bit |
| ie | input | 1 | Global interrupt enable |
| exl | input | 1 | Exception-level flag; blocks requests |
| erl | input | 1 | Error-level flag; blocks requests |
| im | input | 8 | Per-level enable mask |
| timer_idx | input | 3 | Pending bit used by the timer |
| cnt_en | input | 1 | Counter increment enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 32 | Counter load value |
| cmp_wr | input | 1 | Match-value write strobe |
| cmp_wdata | input | 32 | Match-value write data |
| pend | output | 8 | Pending bits |
| any_pend | output | 1 | Any pending bit set |
| irq_req | output | 1 | Registered interrupt request |
| lvl_err | output | 1 | Illegal level seen in the previous cycle |
| count_val | output | 32 | Current counter value |

## Verification
The assertions check the cycle-local rules on every cycle: reset clearing, status gating, the need for an unmasked pending bit, a legal post setting its bit, a timer match setting the indexed bit, illegal levels holding the field and raising the error flag, and counter wrap. Only the bench's scenarios show the precedence cases. These are post against clear, post against clear-all, and timer match against match-value write. The bench scenarios also cover the zero-counter non-match, acknowledgement by rewriting the match value, and exact bit-for-bit pending values across long sequences. The bench compares every output against a reference model on every cycle.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int DEF_NUM_LVL = 8;
    localparam int DEF_LVL_W   = 4;
    localparam int DEF_CNT_W   = 32;

    // status qualifiers that gate the request
    typedef struct packed {
        logic ie;
        logic exl;
        logic erl;
    } irq_stat_t;

    // one level-addressed request
    typedef struct packed {
        logic       vld;
        logic [3:0] lvl;
    } lvl_req_t;

    function automatic logic stat_open(input irq_stat_t s);
        return s.ie && !s.exl && !s.erl;
    endfunction

    function automatic logic lvl_is_bad(input lvl_req_t r, input int num_lvl);
        return r.vld && (int'(r.lvl) >= num_lvl);
    endfunction

endpackage

// File: rtl/irqp_timer.sv
module irqp_timer #(
    parameter int CNT_W = irqp_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] count_q,
    output logic             hit
);
    logic [CNT_W-1:0] match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            match_q <= '0;
        end else begin
            if (cnt_wr)
                count_q <= cnt_wdata;
            else if (cnt_en)
                count_q <= count_q + CNT_W'(1);
            if (cmp_wr)
                match_q <= cmp_wdata;
        end
    end

    // a zero counter never counts as a match
    assign hit = (count_q == match_q) && (count_q != '0);

endmodule

// File: rtl/irqp_pending.sv
module irqp_pending #(
    parameter int NUM_LVL = irqp_pkg::DEF_NUM_LVL,
    parameter int LVL_W   = irqp_pkg::DEF_LVL_W,
    parameter int IDX_W   = $clog2(NUM_LVL)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  irqp_pkg::lvl_req_t   post,
    input  irqp_pkg::lvl_req_t   clr,
    input  logic                 clr_all,
    input  logic                 cmp_wr,
    input  logic                 tmr_hit,
    input  logic [IDX_W-1:0]     tmr_idx,
    output logic [NUM_LVL-1:0]   pend_q,
    output logic                 err_q
);
    logic [NUM_LVL-1:0] set_v;
    logic [NUM_LVL-1:0] drop_v;
    logic [NUM_LVL-1:0] pend_d;

    generate
        for (genvar i = 0; i < NUM_LVL; i++) begin : g_bit
            assign set_v[i]  = (post.vld && (post.lvl == LVL_W'(i)))
                             || (tmr_hit && (tmr_idx == IDX_W'(i)));
            assign drop_v[i] = clr_all
                             || (clr.vld && (clr.lvl == LVL_W'(i)))
                             || (cmp_wr && (tmr_idx == IDX_W'(i)));
            // set takes priority over every clear source
            assign pend_d[i] = set_v[i] | (pend_q[i] & ~drop_v[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            err_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            err_q  <= irqp_pkg::lvl_is_bad(post, NUM_LVL)
                   || irqp_pkg::lvl_is_bad(clr, NUM_LVL);
        end
    end

endmodule

// File: rtl/irqp_gate.sv
module irqp_gate #(
    parameter int NUM_LVL = irqp_pkg::DEF_NUM_LVL
) (
    input  logic                clk,
    input  logic                rst,
    input  irqp_pkg::irq_stat_t stat,
    input  logic [NUM_LVL-1:0]  mask,
    input  logic [NUM_LVL-1:0]  pend,
    output logic                req_q
);
    logic live;

    assign live = |(mask & pend);

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= live && irqp_pkg::stat_open(stat);
    end

endmodule

// File: rtl/irq_pending_unit.sv
module irq_pending_unit #(
    parameter int NUM_LVL = irqp_pkg::DEF_NUM_LVL,
    parameter int LVL_W   = irqp_pkg::DEF_LVL_W,
    parameter int CNT_W   = irqp_pkg::DEF_CNT_W,
    localparam int IDX_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               post_vld,
    input  logic [LVL_W-1:0]   post_lvl,
    input  logic               clr_vld,
    input  logic [LVL_W-1:0]   clr_lvl,
    input  logic               clr_all,
    input  logic               ie,
    input  logic               exl,
    input  logic               erl,
    input  logic [NUM_LVL-1:0] im,
    input  logic [IDX_W-1:0]   timer_idx,
    input  logic               cnt_en,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic               cmp_wr,
    input  logic [CNT_W-1:0]   cmp_wdata,
    output logic [NUM_LVL-1:0] pend,
    output logic               any_pend,
    output logic               irq_req,
    output logic               lvl_err,
    output logic [CNT_W-1:0]   count_val
);
    irqp_pkg::lvl_req_t  post_r;
    irqp_pkg::lvl_req_t  clr_r;
    irqp_pkg::irq_stat_t stat_r;
    logic                tmr_hit;

    assign post_r = '{vld: post_vld, lvl: post_lvl};
    assign clr_r  = '{vld: clr_vld,  lvl: clr_lvl};
    assign stat_r = '{ie: ie, exl: exl, erl: erl};

    irqp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .count_q   (count_val),
        .hit       (tmr_hit)
    );

    irqp_pending #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .post    (post_r),
        .clr     (clr_r),
        .clr_all (clr_all),
        .cmp_wr  (cmp_wr),
        .tmr_hit (tmr_hit),
        .tmr_idx (timer_idx),
        .pend_q  (pend),
        .err_q   (lvl_err)
    );

    irqp_gate #(.NUM_LVL(NUM_LVL)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat_r),
        .mask  (im),
        .pend  (pend),
        .req_q (irq_req)
    );

    assign any_pend = |pend;

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
    parameter int NUM_LVL = irqp_pkg::DEF_NUM_LVL,
    parameter int LVL_W   = irqp_pkg::DEF_LVL_W,
    parameter int CNT_W   = irqp_pkg::DEF_CNT_W,
    parameter int IDX_W   = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst,
    input logic               post_vld,
    input logic [LVL_W-1:0]   post_lvl,
    input logic               clr_vld,
    input logic               clr_all,
    input logic               cmp_wr,
    input logic               cnt_en,
    input logic               cnt_wr,
    input logic               ie,
    input logic               exl,
    input logic               erl,
    input logic [NUM_LVL-1:0] im,
    input logic [IDX_W-1:0]   timer_idx,
    input logic [NUM_LVL-1:0] pend,
    input logic               irq_req,
    input logic               lvl_err,
    input logic [CNT_W-1:0]   count_val,
    input logic               tmr_hit
);
    logic [NUM_LVL-1:0] post_bit_q;
    logic [NUM_LVL-1:0] tmr_bit_q;

    always_ff @(posedge clk) begin
        post_bit_q <= NUM_LVL'(1) << post_lvl[IDX_W-1:0];
        tmr_bit_q  <= NUM_LVL'(1) << timer_idx;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pend == '0) && !irq_req && !lvl_err && (count_val == '0));

    p_post_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (post_vld && (int'(post_lvl) < NUM_LVL)) |=> ((pend & post_bit_q) != '0));

    p_bad_lvl_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (post_vld && (int'(post_lvl) >= NUM_LVL)) |=> lvl_err);

    p_bad_lvl_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (post_vld && (int'(post_lvl) >= NUM_LVL) && !clr_vld && !clr_all
         && !cmp_wr && !tmr_hit) |=> (pend == $past(pend)));

    p_need_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        ((im & pend) == '0) |=> !irq_req);

    p_status_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!ie || exl || erl) |=> !irq_req);

    p_count_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_wr && (count_val == '1)) |=> (count_val == '0));

    p_timer_sets_r9: assert property (@(posedge clk) disable iff (rst)
        tmr_hit |=> ((pend & tmr_bit_q) != '0));

endmodule

bind irq_pending_unit irqp_checker #(
    .NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .post_vld  (post_vld),
    .post_lvl  (post_lvl),
    .clr_vld   (clr_vld),
    .clr_all   (clr_all),
    .cmp_wr    (cmp_wr),
    .cnt_en    (cnt_en),
    .cnt_wr    (cnt_wr),
    .ie        (ie),
    .exl       (exl),
    .erl       (erl),
    .im        (im),
    .timer_idx (timer_idx),
    .pend      (pend),
    .irq_req   (irq_req),
    .lvl_err   (lvl_err),
    .count_val (count_val),
    .tmr_hit   (tmr_hit)
);

// File: tb/sim_irq_pending_unit.sv
module sim_irq_pending_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_vld = 0, clr_vld = 0, clr_all = 0;
    logic [3:0]  post_lvl = 0, clr_lvl = 0;
    logic        ie = 0, exl = 0, erl = 0;
    logic [7:0]  im = 0;
    logic [2:0]  timer_idx = 0;
    logic        cnt_en = 0, cnt_wr = 0, cmp_wr = 0;
    logic [31:0] cnt_wdata = 0, cmp_wdata = 0;
    logic [7:0]  pend;
    logic        any_pend, irq_req, lvl_err;
    logic [31:0] count_val;

    always #5 clk = ~clk;

    irq_pending_unit u0 (
        .clk(clk), .rst(rst),
        .post_vld(post_vld), .post_lvl(post_lvl),
        .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_all(clr_all),
        .ie(ie), .exl(exl), .erl(erl), .im(im), .timer_idx(timer_idx),
        .cnt_en(cnt_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .pend(pend), .any_pend(any_pend), .irq_req(irq_req),
        .lvl_err(lvl_err), .count_val(count_val)
    );

    typedef struct packed {
        logic [7:0]  pend;
        logic        any;
        logic        irq;
        logic        err;
        logic [31:0] cnt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // reference state derived from the requirements
    logic [7:0]  m_pend = 0;
    logic [31:0] m_cnt = 0, m_cmp = 0;

    task automatic cyc(input string tag);
        exp_t        e;
        logic [7:0]  np;
        logic [31:0] nc, nm;
        logic        hit, ir, er;
        if (rst) begin
            np = 0; nc = 0; nm = 0; ir = 0; er = 0;
        end else begin
            hit = (m_cnt == m_cmp) && (m_cnt != 0);                    // R9 R10
            nc  = cnt_wr ? cnt_wdata : (cnt_en ? m_cnt + 32'd1 : m_cnt); // R8
            nm  = cmp_wr ? cmp_wdata : m_cmp;
            for (int i = 0; i < 8; i++) begin
                logic s, c;
                s = (post_vld && post_lvl == 4'(i)) || (hit && timer_idx == 3'(i));
                c = clr_all || (clr_vld && clr_lvl == 4'(i))
                    || (cmp_wr && timer_idx == 3'(i));                  // R11
                np[i] = s | (m_pend[i] & ~c);                           // R5
            end
            ir = ie && !exl && !erl && ((im & m_pend) != 0);            // R6 R7
            er = (post_vld && post_lvl > 7) || (clr_vld && clr_lvl > 7); // R4
        end
        e.pend = np; e.any = (np != 0); e.irq = ir; e.err = er; e.cnt = nc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        m_pend = np; m_cnt = nc; m_cmp = nm;
        #1;
        post_vld = 0; clr_vld = 0; clr_all = 0; cnt_wr = 0; cmp_wr = 0;
    endtask

    // monitor: pop one expectation per edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (pend !== e.pend || any_pend !== e.any || irq_req !== e.irq
                    || lvl_err !== e.err || count_val !== e.cnt) begin
                    n_bad++;
                    $display("FAIL %s: pend=%h any=%b irq=%b err=%b cnt=%h exp pend=%h any=%b irq=%b err=%b cnt=%h",
                             t, pend, any_pend, irq_req, lvl_err, count_val,
                             e.pend, e.any, e.irq, e.err, e.cnt);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc("R1 reset"); cyc("R1 reset");
        rst = 0;
        cyc("R1 idle after reset");

        // legal posts with masked request
        post_vld = 1; post_lvl = 3; cyc("R2 post 3");
        post_vld = 1; post_lvl = 0; cyc("R2 post 0");
        post_vld = 1; post_lvl = 7; cyc("R2 post 7");
        cyc("R12 any_pend with im=0"); cyc("R6 no unmasked bit");

        // enable and gate
        ie = 1; im = 8'h08; cyc("R6 enable"); cyc("R6 request high");
        exl = 1; cyc("R7 exl"); cyc("R7 exl held");
        exl = 0; erl = 1; cyc("R7 erl"); cyc("R7 erl held");
        erl = 0; ie = 0; cyc("R7 ie low"); cyc("R7 ie low held");
        ie = 1; cyc("R6 reopen"); cyc("R6 reopen high");

        // clears
        clr_vld = 1; clr_lvl = 3; cyc("R3 clear 3"); cyc("R6 drop after clear");
        clr_all = 1; cyc("R3 clear all"); cyc("R12 empty");

        // illegal levels
        post_vld = 1; post_lvl = 5; cyc("R2 post 5");
        post_vld = 1; post_lvl = 9; cyc("R4 bad post");
        clr_vld = 1; clr_lvl = 12; cyc("R4 bad clear");
        cyc("R4 error gone");

        // precedence
        post_vld = 1; post_lvl = 2; clr_vld = 1; clr_lvl = 2; cyc("R5 post vs clear");
        post_vld = 1; post_lvl = 6; clr_all = 1; cyc("R5 post vs clear all");
        clr_all = 1; cyc("R3 clear all again");

        // timer match
        timer_idx = 5; im = 8'h20;
        cnt_wr = 1; cnt_wdata = 100; cmp_wr = 1; cmp_wdata = 103; cyc("R8 load");
        cnt_en = 1;
        for (int k = 0; k < 5; k++) cyc("R9 run to match");
        cnt_en = 0; cyc("R9 bit held"); cyc("R6 timer request");
        cmp_wr = 1; cmp_wdata = 5000; cyc("R11 ack by write");
        cyc("R11 cleared");

        // match and write in same cycle
        cnt_wr = 1; cnt_wdata = 200; cmp_wr = 1; cmp_wdata = 200; cyc("R5 arm");
        cmp_wr = 1; cmp_wdata = 200; cyc("R5 hit vs write");
        cmp_wr = 1; cmp_wdata = 7; cyc("R11 ack"); cyc("R11 cleared again");

        // zero match is ignored
        cnt_wr = 1; cnt_wdata = 0; cmp_wr = 1; cmp_wdata = 0; cyc("R10 zero");
        cyc("R10 zero hold"); cyc("R10 zero hold");

        // wrap
        cnt_wr = 1; cnt_wdata = 32'hFFFF_FFFE; cyc("R8 preload");
        cnt_en = 1;
        for (int k = 0; k < 4; k++) cyc("R8 wrap");
        cnt_wr = 1; cnt_wdata = 32'h10; cyc("R8 load beats increment");
        cnt_en = 0; cyc("R8 hold");

        @(posedge clk); #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule